// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block connects a small 8-bit processor core to external code and data memories over a narrow, pin-saving bus. Every external access takes exactly one machine cycle of 12 clocks. The low half of the 16-bit address and the data byte share one 8-bit bus, one after the other in time. The upper address byte goes out on a second 8-bit port. An address strobe tells an outside latch when to capture the low address byte. Code fetches and data accesses use different strobes. A code fetch pulses the program-store enable. A data access pulses either the read strobe or the write strobe. All strobes are active low.

The core holds a request, made of a kind, an address and write data, until it sees the acknowledge. The block takes requests only on the edge that closes a machine cycle. It answers in the last clock of the access cycle and returns the read byte in that same clock. If the core puts up a new request during the acknowledge clock, the next access follows with no idle cycle. When no access is running, the shared bus drives the low port-latch value and the upper port drives the high port-latch value. Both follow their latch inputs one clock later.

Top module: `xbus_seq`

## Requirements
- R1: While reset is held and after it is released, until the first access, `ale` is 0, the three active-low strobes are 1 and `req_ack` is 0. During reset itself, `ad_out` and `hi_out` are all ones and `ad_oe` is 1.
- R2: The machine-cycle counter restarts at reset release. Clock n after release is phase n mod 12. A request is taken only on the edge that ends phase 11; one raised earlier waits there with `ale` low. In clocks 1 and 2 of an access, `ale` is 1 and `ad_out` carries address bits 7:0 with `ad_oe` 1.
- R3: A code fetch (kind 0) drives `psen_n` low in clocks 4 to 11 and leaves `rd_n` and `wr_n` high. At most one strobe is ever low.
- R4: A data read (kind 1) drives `rd_n` low in clocks 4 to 11. In clocks 3 to 12 it releases the bus (`ad_oe` 0, `ad_out` all ones). `ad_in` is sampled at the end of clock 11 and shown on `rsp_rdata` in clock 12. A code fetch returns its byte the same way.
- R5: A data write (kind 2) drives `wr_n` low in clocks 4 to 11 and drives `req_wdata` on `ad_out` with `ad_oe` 1 in clocks 3 to 12.
- R6: `hi_out` carries address bits 15:8 in all 12 clocks of an access.
- R7: `req_ack` is 1 for exactly one clock, clock 12, of every access of kinds 0, 1 and 2.
- R8: When no access is running, `ale` is 0, the strobes are 1, `ad_oe` is 1, and `ad_out` and `hi_out` show `lo_latch` and `hi_latch` one clock after those inputs change.
- R9: A request of kind 3 starts no access. The pins stay in the idle state of R8 and no acknowledge is given.
- R10: A request present on the edge that ends an acknowledge clock is taken on that edge. Its clock 1, with `ale` high, follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request pending |
| req_kind | input | 2 | 0 code fetch, 1 data read, 2 data write, 3 reserved |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| req_ack | output | 1 | Access completes in this clock |
| rsp_rdata | output | 8 | Byte read by the latest fetch or read |
| lo_latch | input | 8 | Low port-latch value for idle time |
| hi_latch | input | 8 | High port-latch value for idle time |
| ad_in | input | 8 | Shared bus as seen from the pins |
| ad_out | output | 8 | Shared bus drive value (address low / data) |
| ad_oe | output | 1 | Shared bus output enable |
| hi_out | output | 8 | Upper address port |
| ale | output | 1 | Address latch strobe, high while address is on the bus |
| psen_n | output | 1 | Code memory read strobe, active low |
| rd_n | output | 1 | Data memory read strobe, active low |
| wr_n | output | 1 | Data memory write strobe, active low |

## Verification
The acknowledge of one access and the capture of the next request fall on the same edge. In that clock the returned byte, the end of the old address on `hi_out` and the start of a new address strobe all meet. The bench chains a series of fetches, reads and writes without a break. It puts up each new request in the acknowledge clock of the one before. It then checks that the following clock already shows `ale` high with the new address, and that the previous read byte is correct on `rsp_rdata`. A request raised in the middle of an idle cycle is also checked: it must wait for the boundary.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    XK_CODE = 2'd0,
    XK_DRD  = 2'd1,
    XK_DWR  = 2'd2,
    XK_RSVD = 2'd3
  } xkind_e;
endpackage

// File: rtl/xbus_phase.sv
// Free-running machine-cycle phase counter.
module xbus_phase #(
  parameter int CYC_LEN = 12,
  parameter int PH_W    = $clog2(CYC_LEN)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] ph,
  output logic [PH_W-1:0] nph,
  output logic            wrap
);
  localparam logic [PH_W-1:0] LAST = PH_W'(CYC_LEN - 1);

  assign wrap = (ph == LAST);
  assign nph  = wrap ? '0 : ph + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) ph <= '0;
    else     ph <= nph;
  end
endmodule

// File: rtl/xbus_slot.sv
// Holds the access owning the current machine cycle; loads at the cycle boundary.
module xbus_slot
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrap,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          act,
  output xkind_e        kind,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          nact,
  output xkind_e        nkind,
  output logic [AW-1:0] naddr,
  output logic [DW-1:0] nwdata
);
  xkind_e in_kind;
  assign in_kind = xkind_e'(req_kind);

  always_comb begin
    if (wrap) begin
      nact   = req_valid && (in_kind != XK_RSVD);
      nkind  = in_kind;
      naddr  = req_addr;
      nwdata = req_wdata;
    end else begin
      nact   = act;
      nkind  = kind;
      naddr  = addr;
      nwdata = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act   <= 1'b0;
      kind  <= XK_CODE;
      addr  <= '0;
      wdata <= '0;
    end else begin
      act   <= nact;
      kind  <= nkind;
      addr  <= naddr;
      wdata <= nwdata;
    end
  end
endmodule

// File: rtl/xbus_pins.sv
// Registered pin driver: decodes the upcoming phase and access into pin levels.
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int CYC_LEN   = 12,
  parameter int PH_W      = $clog2(CYC_LEN),
  parameter int ALE_LAST  = 1,
  parameter int STB_FIRST = 3,
  parameter int STB_LAST  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PH_W-1:0]  nph,
  input  logic             nact,
  input  xkind_e           nkind,
  input  logic [AW-1:0]    naddr,
  input  logic [DW-1:0]    nwdata,
  input  logic [DW-1:0]    lo_latch,
  input  logic [AW-DW-1:0] hi_latch,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic [AW-DW-1:0] hi_out,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n
);
  localparam int HW = AW - DW;
  localparam logic [PH_W-1:0] ALE_END = PH_W'(ALE_LAST);
  localparam logic [PH_W-1:0] S_FIRST = PH_W'(STB_FIRST);
  localparam logic [PH_W-1:0] S_LAST  = PH_W'(STB_LAST);

  logic          addr_win, stb_win;
  logic [DW-1:0] ad_d;
  logic          oe_d;
  logic [HW-1:0] hi_d;

  assign addr_win = nact && (nph <= ALE_END);
  assign stb_win  = nact && (nph >= S_FIRST) && (nph <= S_LAST);

  always_comb begin
    if (!nact) begin
      ad_d = lo_latch;
      oe_d = 1'b1;
      hi_d = hi_latch;
    end else begin
      hi_d = naddr[AW-1:DW];
      if (addr_win) begin
        ad_d = naddr[DW-1:0];
        oe_d = 1'b1;
      end else if (nkind == XK_DWR) begin
        ad_d = nwdata;
        oe_d = 1'b1;
      end else begin
        ad_d = '1;
        oe_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out <= '1;
      ad_oe  <= 1'b1;
      hi_out <= '1;
      ale    <= 1'b0;
      psen_n <= 1'b1;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
    end else begin
      ad_out <= ad_d;
      ad_oe  <= oe_d;
      hi_out <= hi_d;
      ale    <= addr_win;
      psen_n <= !(stb_win && nkind == XK_CODE);
      rd_n   <= !(stb_win && nkind == XK_DRD);
      wr_n   <= !(stb_win && nkind == XK_DWR);
    end
  end
endmodule

// File: rtl/xbus_resp.sv
// Captures the returned byte and raises the completion pulse.
module xbus_resp
  import xbus_pkg::*;
#(
  parameter int DW        = 8,
  parameter int CYC_LEN   = 12,
  parameter int PH_W      = $clog2(CYC_LEN),
  parameter int SAMPLE_PH = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            act,
  input  xkind_e          kind,
  input  logic [PH_W-1:0] ph,
  input  logic [DW-1:0]   ad_in,
  output logic            ack,
  output logic [DW-1:0]   rdata
);
  localparam logic [PH_W-1:0] ACK_PRE = PH_W'(CYC_LEN - 2);
  localparam logic [PH_W-1:0] SMP     = PH_W'(SAMPLE_PH);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= act && (ph == ACK_PRE);
      if (act && (ph == SMP) && (kind != XK_DWR)) rdata <= ad_in;
    end
  end
endmodule

// File: rtl/xbus_seq.sv
// Multiplexed external memory bus sequencer, top level.
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int CYC_LEN   = 12,
  parameter int ALE_LAST  = 1,
  parameter int STB_FIRST = 3,
  parameter int STB_LAST  = 10,
  parameter int SAMPLE_PH = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ack,
  output logic [DW-1:0]    rsp_rdata,
  input  logic [DW-1:0]    lo_latch,
  input  logic [AW-DW-1:0] hi_latch,
  input  logic [DW-1:0]    ad_in,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic [AW-DW-1:0] hi_out,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n
);
  localparam int PH_W = $clog2(CYC_LEN);

  logic [PH_W-1:0] ph, nph;
  logic            wrap;
  logic            act, nact;
  xkind_e          kind, nkind;
  logic [AW-1:0]   addr, naddr;
  logic [DW-1:0]   wdata, nwdata;

  xbus_phase #(.CYC_LEN(CYC_LEN), .PH_W(PH_W)) u_phase (
    .clk(clk), .rst(rst), .ph(ph), .nph(nph), .wrap(wrap)
  );

  xbus_slot #(.AW(AW), .DW(DW)) u_slot (
    .clk(clk), .rst(rst), .wrap(wrap),
    .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .act(act), .kind(kind), .addr(addr), .wdata(wdata),
    .nact(nact), .nkind(nkind), .naddr(naddr), .nwdata(nwdata)
  );

  xbus_pins #(
    .AW(AW), .DW(DW), .CYC_LEN(CYC_LEN), .PH_W(PH_W),
    .ALE_LAST(ALE_LAST), .STB_FIRST(STB_FIRST), .STB_LAST(STB_LAST)
  ) u_pins (
    .clk(clk), .rst(rst), .nph(nph), .nact(nact), .nkind(nkind),
    .naddr(naddr), .nwdata(nwdata),
    .lo_latch(lo_latch), .hi_latch(hi_latch),
    .ad_out(ad_out), .ad_oe(ad_oe), .hi_out(hi_out), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  xbus_resp #(
    .DW(DW), .CYC_LEN(CYC_LEN), .PH_W(PH_W), .SAMPLE_PH(SAMPLE_PH)
  ) u_resp (
    .clk(clk), .rst(rst), .act(act), .kind(kind), .ph(ph),
    .ad_in(ad_in), .ack(req_ack), .rdata(rsp_rdata)
  );

  logic unused_ok;
  assign unused_ok = ^{addr, wdata};
endmodule

// File: rtl/xbus_seq_chk.sv
// Property checker attached to the sequencer top.
module xbus_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ack,
  input logic             ad_oe,
  input logic [AW-DW-1:0] hi_out,
  input logic             ale,
  input logic             psen_n,
  input logic             rd_n,
  input logic             wr_n
);
  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

  assert_ale_no_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    ale |-> (psen_n && rd_n && wr_n));

  assert_ack_single_R7: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);

  assert_read_float_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);

  assert_write_drive_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> ad_oe);

  assert_hi_hold_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> $stable(hi_out));
endmodule

bind xbus_seq xbus_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .req_ack(req_ack), .ad_oe(ad_oe), .hi_out(hi_out),
  .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
);

// File: tb/xbus_seq_test.sv
`timescale 1ns/1ps
module xbus_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic        req_ack;
  logic [7:0]  rsp_rdata;
  logic [7:0]  lo_latch = 8'h3C;
  logic [7:0]  hi_latch = 8'hA5;
  logic [7:0]  ad_in;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  hi_out;
  logic        ale, psen_n, rd_n, wr_n;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;
  logic [15:0] cur_addr = 16'h0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // Memory model: returns a byte derived from the address while a read strobe is low.
  assign ad_in = (!rd_n || !psen_n) ? (cur_addr[7:0] ^ cur_addr[15:8] ^ 8'hC3) : 8'h00;

  xbus_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .rsp_rdata(rsp_rdata), .lo_latch(lo_latch), .hi_latch(hi_latch),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .hi_out(hi_out),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic idle_pins(input string tag);
    chk(ale == 1'b0, tag, {15'd0, ale}, 16'd0);
    chk({psen_n, rd_n, wr_n} == 3'b111, tag, {13'd0, psen_n, rd_n, wr_n}, 16'h7);
    chk(ad_oe == 1'b1, tag, {15'd0, ad_oe}, 16'd1);
    chk(ad_out == lo_latch, tag, {8'd0, ad_out}, {8'd0, lo_latch});
    chk(hi_out == hi_latch, tag, {8'd0, hi_out}, {8'd0, hi_latch});
  endtask

  // One access; returns at the negedge of its acknowledge clock (phase 11).
  task automatic run_access(input int kind, input logic [15:0] a, input logic [7:0] wd,
                            input bit early, input bit chained);
    logic [7:0] pat;
    if (chained) chk((cyc % 12) == 11, "R10 chain at boundary", 16'(cyc % 12), 16'd11);
    if (early) begin
      while ((cyc % 12) != 4) @(negedge clk);
    end else begin
      while ((cyc % 12) != 11) @(negedge clk);
    end
    req_valid = 1'b1;
    req_kind  = 2'(kind);
    req_addr  = a;
    req_wdata = wd;
    if (early) begin
      while ((cyc % 12) != 11) begin
        @(negedge clk);
        chk(ale == 1'b0 && req_ack == 1'b0, "R2 wait for boundary", {15'd0, ale}, 16'd0);
      end
    end
    cur_addr = a;
    pat = a[7:0] ^ a[15:8] ^ 8'hC3;
    for (int k = 0; k < 12; k++) begin
      int  c;
      bit  stb;
      logic [7:0] exp_ad;
      bit  exp_oe;
      @(negedge clk);
      c   = k + 1;
      stb = (c >= 4) && (c <= 11);
      chk(ale == (c <= 2), chained && c == 1 ? "R10 ale right after ack" : "R2 ale window",
          {15'd0, ale}, {15'd0, c <= 2});
      chk(hi_out == a[15:8], "R6 high address", {8'd0, hi_out}, {8'd0, a[15:8]});
      chk(psen_n == !(kind == 0 && stb), "R3 psen_n", {15'd0, psen_n}, {15'd0, !(kind == 0 && stb)});
      chk(rd_n == !(kind == 1 && stb), "R4 rd_n", {15'd0, rd_n}, {15'd0, !(kind == 1 && stb)});
      chk(wr_n == !(kind == 2 && stb), "R5 wr_n", {15'd0, wr_n}, {15'd0, !(kind == 2 && stb)});
      if (c <= 2) begin
        exp_ad = a[7:0]; exp_oe = 1'b1;
      end else if (kind == 2) begin
        exp_ad = wd; exp_oe = 1'b1;
      end else begin
        exp_ad = 8'hFF; exp_oe = 1'b0;
      end
      chk(ad_oe == exp_oe, c <= 2 ? "R2 bus enable" : (kind == 2 ? "R5 bus enable" : "R4 bus release"),
          {15'd0, ad_oe}, {15'd0, exp_oe});
      chk(ad_out == exp_ad, c <= 2 ? "R2 low address" : (kind == 2 ? "R5 write data" : "R4 floating ones"),
          {8'd0, ad_out}, {8'd0, exp_ad});
      chk(req_ack == (c == 12), "R7 ack in last clock", {15'd0, req_ack}, {15'd0, c == 12});
      if (c == 12 && kind != 2)
        chk(rsp_rdata == pat, "R4 read data", {8'd0, rsp_rdata}, {8'd0, pat});
    end
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk(ale == 1'b0 && req_ack == 1'b0, "R1 reset ale/ack", {14'd0, ale, req_ack}, 16'd0);
    chk({psen_n, rd_n, wr_n} == 3'b111, "R1 reset strobes", {13'd0, psen_n, rd_n, wr_n}, 16'h7);
    chk(ad_out == 8'hFF && hi_out == 8'hFF && ad_oe, "R1 reset ports", {ad_out, hi_out}, 16'hFFFF);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(ale == 1'b0 && req_ack == 1'b0, "R1 after release", {14'd0, ale, req_ack}, 16'd0);
    idle_pins("R8 idle after reset");

    // R2: request raised mid-cycle waits for the boundary
    run_access(1, 16'h1234, 8'h00, 1'b1, 1'b0);
    req_valid = 1'b0;
    @(negedge clk);
    idle_pins("R8 idle after access");

    // Chained sweep of all three kinds over a set of addresses
    for (int i = 0; i < 10; i++) begin
      for (int kd = 0; kd < 3; kd++) begin
        if (i == 0)      a = 16'h0000;
        else if (i == 9) a = 16'hFFFF;
        else             a = 16'((i * 16'h2493) ^ (kd << 12) ^ (i << 3));
        run_access(kd, a, 8'(~a[7:0] ^ 8'(i * 7 + kd)), 1'b0, !(i == 0 && kd == 0));
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    idle_pins("R8 idle after chain");

    // R8: idle ports follow latch inputs with one clock delay
    for (int j = 0; j < 6; j++) begin
      lo_latch = 8'(8'h96 + j * 37);
      hi_latch = 8'(8'h69 ^ (j * 19));
      @(negedge clk);
      idle_pins("R8 latch follow");
    end

    // R9: reserved kind starts nothing
    while ((cyc % 12) != 11) @(negedge clk);
    req_valid = 1'b1;
    req_kind  = 2'd3;
    req_addr  = 16'hBEEF;
    req_wdata = 8'h55;
    for (int k = 0; k < 13; k++) begin
      @(negedge clk);
      idle_pins("R9 reserved kind");
      chk(req_ack == 1'b0, "R9 no ack", {15'd0, req_ack}, 16'd0);
    end
    req_valid = 1'b0;

    // One more isolated write then read after the reserved request
    run_access(2, 16'h8001, 8'h5A, 1'b0, 1'b0);
    run_access(0, 16'h7FFE, 8'h00, 1'b0, 1'b1);
    req_valid = 1'b0;
    @(negedge clk);
    idle_pins("R8 idle at end");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule